// File: doc/BRIEF.md
# Multiplexed Address/Data Parallel Port Controller

This block connects an internal requester to external memory over one shared 16-bit bus. The bus carries the address in one phase and the data in the next. The requester offers an access with a valid/ready handshake. Each access gives a direction, a 24-bit address, write data, and a width flag that selects a byte access or a halfword access.

The controller runs three phases:

- **Address phase.** The address is placed on the pins while the address latch enable (ALE) is asserted.
- **Strobe phase.** The active-low read or write strobe is asserted.
- **Hold phase.** The strobes are high again.

The length of each phase is configured separately. Read data is returned together with a one-cycle done pulse.

For byte accesses, an external latch keeps address bits 23..8. The controller tracks the last value it latched, and the address phase is issued only when those bits change. The low address byte then travels on the upper byte lane during the strobe phase. The polarity of ALE is selectable. A flag mode gives the pins to general-purpose use: all strobes stay inactive, the bus is released, and any access in flight is abandoned.

Top module: `mux_bus_port`

## Requirements
- R1: After reset, `bus_oe` is 2'b00, `rd_n` and `wr_n` are 1, `ale` is 0 (active-high default), `done` is 0 and `req_ready` is 1.
- R2: A halfword access (`req_wide`=1) always has an address phase. During that phase, `ale` is active for max(1,`cfg_addr_cycles`) cycles, `bus_out` equals address bits 15..0, and `bus_oe` is 2'b11.
- R3: A byte access has an address phase only when address bits 23..8 differ from the last value latched by a byte access. The tracked value is invalid after reset, after any halfword access and after a flag-mode abort. During that phase `bus_out` carries address bits 23..8.
- R4: With `cfg_ale_low`=1, `ale` idles at 1 and is driven to 0 during the address phase.
- R5: A write holds `wr_n` low for max(1,`cfg_strobe_cycles`) cycles, with `rd_n` high throughout. During the strobe, `bus_oe` is 2'b11. `bus_out` is `req_wdata` for a halfword access, and {address bits 7..0, write data bits 7..0} for a byte access.
- R6: A read holds `rd_n` low for max(1,`cfg_strobe_cycles`) cycles.
  - For a halfword read, `bus_oe` is 2'b00 during the strobe.
  - For a byte read, `bus_oe` is 2'b10, with `bus_out[15:8]` equal to address bits 7..0.
  - `rdata` is `bus_in` sampled in the last strobe cycle, or {8'h00, `bus_in[7:0]`} for a byte read.
- R7: Each completed access raises `done` for exactly one cycle, in the first cycle after the strobe phase, and `rdata` is valid in that cycle.
- R8: After the strobe, a hold phase of max(1,`cfg_hold_cycles`) cycles passes with both strobes high and `ale` inactive before `req_ready` returns.
- R9: While `cfg_flag_mode` is 1, `req_ready` is 0. From the next cycle on, the strobes are high, `ale` is at its inactive level and `bus_oe` is 2'b00. An access in flight ends without `done`.
- R10: A phase-length field of 0 behaves as a length of 1.
- R11: An access starts only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is 0 while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_flag_mode | input | 1 | Hand the pins to general-purpose use |
| cfg_ale_low | input | 1 | 1 selects active-low ALE |
| cfg_addr_cycles | input | 4 | Address phase length (0 means 1) |
| cfg_strobe_cycles | input | 4 | Strobe phase length (0 means 1) |
| cfg_hold_cycles | input | 4 | Hold phase length (0 means 1) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 halfword, 0 byte |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data |
| bus_in | input | 16 | Sampled pin values |
| bus_out | output | 16 | Driven pin values |
| bus_oe | output | 2 | Output enable per byte lane (bit 1 = upper) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ale | output | 1 | Address latch enable |

## Verification
Flag mode can be raised in the same cycle that a request is offered, or in the middle of a strobe. In both cases the pin hand-over competes with the access sequencer.

The bench provokes both cases. The first is a request held valid while flag mode is high. The second is flag mode raised while a long read strobe is low. In the first case, the bench judges that no strobe or address phase appears. In the second, it judges that `rd_n` rises on the next cycle, that `done` never pulses, and that the next byte access issues a fresh address phase.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_STRB, ST_HOLD} mbp_state_e;

  // map a configured phase length to a timer preload (0 and 1 both give one cycle)
  function automatic logic [3:0] phase_preload(input logic [3:0] len);
    return (len == 4'd0) ? 4'd0 : len - 4'd1;
  endfunction
endpackage

// File: rtl/mbp_phase_timer.sv
module mbp_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/mbp_upper_track.sv
module mbp_upper_track #(
  parameter int UW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic [UW-1:0] load_val,
  input  logic [UW-1:0] cmp_val,
  output logic          differ
);
  logic          valid_q;
  logic [UW-1:0] upper_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      upper_q <= '0;
    end else if (clear) begin
      valid_q <= 1'b0;
    end else if (load) begin
      valid_q <= 1'b1;
      upper_q <= load_val;
    end
  end

  assign differ = !valid_q || (upper_q != cmp_val);

  // R3: once the latch contents are unknown, the next byte access must latch again
  assert_clear_forces_latch_R3: assert property (@(posedge clk) disable iff (rst)
    clear |=> differ);
endmodule

// File: rtl/mbp_pin_drive.sv
module mbp_pin_drive import mbp_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  mbp_state_e        state,
  input  logic              write,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ale_low,
  output logic [DATA_W-1:0] bus_out,
  output logic [1:0]        bus_oe,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ale
);
  localparam int BYTE_W = DATA_W / 2;

  logic ale_act;
  logic [DATA_W-1:0] data_word;
  logic [1:0]        data_oe;

  // data-phase lane contents: a byte access carries the low address byte upstairs
  always_comb begin
    if (wide) begin
      data_word = write ? wdata : '0;
      data_oe   = write ? 2'b11 : 2'b00;
    end else begin
      data_word = {addr[BYTE_W-1:0], (write ? wdata[BYTE_W-1:0] : {BYTE_W{1'b0}})};
      data_oe   = {1'b1, write};
    end
  end

  always_comb begin
    bus_out = '0;
    bus_oe  = 2'b00;
    rd_n    = 1'b1;
    wr_n    = 1'b1;
    ale_act = 1'b0;
    unique case (state)
      ST_ADDR: begin
        ale_act = 1'b1;
        bus_oe  = 2'b11;
        bus_out = wide ? addr[DATA_W-1:0] : addr[ADDR_W-1:BYTE_W];
      end
      ST_STRB: begin
        bus_out = data_word;
        bus_oe  = data_oe;
        rd_n    = write;
        wr_n    = !write;
      end
      ST_HOLD: begin
        bus_out = data_word;
        bus_oe  = data_oe;
      end
      default: ;
    endcase
    ale = ale_act ^ ale_low;
  end
endmodule

// File: rtl/mux_bus_port.sv
module mux_bus_port import mbp_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_flag_mode,
  input  logic              cfg_ale_low,
  input  logic [CNT_W-1:0]  cfg_addr_cycles,
  input  logic [CNT_W-1:0]  cfg_strobe_cycles,
  input  logic [CNT_W-1:0]  cfg_hold_cycles,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [1:0]        bus_oe,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ale
);
  localparam int BYTE_W  = DATA_W / 2;
  localparam int UPPER_W = ADDR_W - BYTE_W;

  mbp_state_e state_q, state_d;
  logic              wr_q, wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept, tmr_load, tmr_last, strobe_end, differ;
  logic [CNT_W-1:0]  tmr_val;
  logic              cur_wr, cur_wide;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic [DATA_W-1:0] pin_out;
  logic [1:0]        pin_oe;
  logic              pin_rd_n, pin_wr_n, pin_ale;

  assign req_ready = (state_q == ST_IDLE) && !cfg_flag_mode;
  assign accept    = req_valid && req_ready;

  // ----- sequencer -----
  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    strobe_end = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (req_wide || differ) begin
          state_d = ST_ADDR;
          tmr_val = phase_preload(cfg_addr_cycles);
        end else begin
          state_d = ST_STRB;
          tmr_val = phase_preload(cfg_strobe_cycles);
        end
      end
      ST_ADDR: if (tmr_last) begin
        state_d  = ST_STRB;
        tmr_load = 1'b1;
        tmr_val  = phase_preload(cfg_strobe_cycles);
      end
      ST_STRB: if (tmr_last) begin
        state_d    = ST_HOLD;
        tmr_load   = 1'b1;
        tmr_val    = phase_preload(cfg_hold_cycles);
        strobe_end = 1'b1;
      end
      ST_HOLD: if (tmr_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (cfg_flag_mode) begin
      state_d    = ST_IDLE;
      strobe_end = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        wr_q    <= req_write;
        wide_q  <= req_wide;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign cur_wr    = accept ? req_write : wr_q;
  assign cur_wide  = accept ? req_wide  : wide_q;
  assign cur_addr  = accept ? req_addr  : addr_q;
  assign cur_wdata = accept ? req_wdata : wdata_q;

  mbp_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  mbp_upper_track #(.UW(UPPER_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .clear    ((accept && req_wide) || (cfg_flag_mode && state_q != ST_IDLE)),
    .load     (accept && !req_wide),
    .load_val (req_addr[ADDR_W-1:BYTE_W]),
    .cmp_val  (req_addr[ADDR_W-1:BYTE_W]),
    .differ   (differ)
  );

  mbp_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state(state_d), .write(cur_wr), .wide(cur_wide), .addr(cur_addr),
    .wdata(cur_wdata), .ale_low(cfg_ale_low),
    .bus_out(pin_out), .bus_oe(pin_oe), .rd_n(pin_rd_n), .wr_n(pin_wr_n), .ale(pin_ale)
  );

  // ----- registered pin and result outputs -----
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 2'b00;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      ale     <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      bus_out <= pin_out;
      bus_oe  <= pin_oe;
      rd_n    <= pin_rd_n;
      wr_n    <= pin_wr_n;
      ale     <= pin_ale;
      done    <= strobe_end;
      if (strobe_end && !wr_q)
        rdata <= wide_q ? bus_in : {{BYTE_W{1'b0}}, bus_in[BYTE_W-1:0]};
    end
  end

  // ----- assertions -----
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  assert_read_releases_bus_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !bus_oe[0]);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(!rd_n || !wr_n));

  assert_flag_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_flag_mode)) |->
      (rd_n && wr_n && bus_oe == 2'b00 && ale == $past(cfg_ale_low)));

  assert_ready_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (rd_n && wr_n));
endmodule

// File: tb/test_mux_bus_port.sv
module test_mux_bus_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_flag_mode = 1'b0, cfg_ale_low = 1'b0;
  logic [3:0] cfg_addr_cycles = 4'd2, cfg_strobe_cycles = 4'd3, cfg_hold_cycles = 4'd1;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_in = '0;
  logic req_ready, done, rd_n, wr_n, ale;
  logic [15:0] rdata, bus_out;
  logic [1:0] bus_oe;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_port i_mux_bus_port (
    .clk(clk), .rst(rst), .cfg_flag_mode(cfg_flag_mode), .cfg_ale_low(cfg_ale_low),
    .cfg_addr_cycles(cfg_addr_cycles), .cfg_strobe_cycles(cfg_strobe_cycles),
    .cfg_hold_cycles(cfg_hold_cycles), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .rd_n(rd_n), .wr_n(wr_n), .ale(ale)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // vector fields: {wide, write, addr[23:0], data[15:0], expect_address_phase}
  localparam int NV = 8;
  localparam logic [42:0] VECS [NV] = '{
    {1'b0, 1'b1, 24'h123456, 16'h00A5, 1'b1},  // first byte access: always latches
    {1'b0, 1'b1, 24'h123457, 16'h003C, 1'b0},  // same upper bits: skipped
    {1'b0, 1'b0, 24'h1234FF, 16'h0000, 1'b0},  // byte read, skipped
    {1'b0, 1'b0, 24'h123500, 16'h0000, 1'b1},  // upper bits change
    {1'b1, 1'b1, 24'hABCDEF, 16'hBEEF, 1'b1},  // halfword write
    {1'b0, 1'b1, 24'h123501, 16'h0011, 1'b1},  // tracker invalidated by halfword
    {1'b1, 1'b0, 24'h000010, 16'h0000, 1'b1},  // halfword read
    {1'b1, 1'b1, 24'h000010, 16'h1234, 1'b1}   // repeated halfword still latches
  };

  // issue one access and observe every phase at the pins
  task automatic run_access(input bit wide, input bit write, input logic [23:0] addr,
                            input logic [15:0] data, input bit exp_alep);
    int ale_c = 0, rd_c = 0, wr_c = 0, hold_c = 0, done_c = 0;
    logic [15:0] ale_bus = '0, wr_bus = '0, rd_bus = '0, got = '0, expd;
    logic [1:0] wr_oe = '0, rd_oe = '0;
    int na = eff(cfg_addr_cycles), ns = eff(cfg_strobe_cycles), nh = eff(cfg_hold_cycles);
    @(negedge clk);
    req_wide = wide; req_write = write; req_addr = addr; req_wdata = data;
    bus_in = addr[15:0] ^ 16'h5A5A;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 80; k++) begin
      if (req_ready) break;
      if (ale != cfg_ale_low) begin ale_c++; ale_bus = bus_out; end
      if (!wr_n) begin wr_c++; wr_bus = bus_out; wr_oe = bus_oe; end
      if (!rd_n) begin rd_c++; rd_bus = bus_out; rd_oe = bus_oe; end
      if (rd_n && wr_n && ale == cfg_ale_low) hold_c++;
      if (done) begin done_c++; got = rdata; end
      @(negedge clk);
    end
    chk(ale_c == (exp_alep ? na : 0), wide ? "R2 address phase length" : "R3 address phase presence",
        ale_c, exp_alep ? na : 0);
    if (exp_alep)
      chk(ale_bus == (wide ? addr[15:0] : addr[23:8]), wide ? "R2 address on bus" : "R3 upper address on bus",
          ale_bus, wide ? addr[15:0] : addr[23:8]);
    if (write) begin
      chk(wr_c == ns && rd_c == 0, "R5 write strobe cycles", wr_c, ns);
      expd = wide ? data : {addr[7:0], data[7:0]};
      chk(wr_bus == expd && wr_oe == 2'b11, "R5 write data on bus", {wr_oe, wr_bus}, {2'b11, expd});
    end else begin
      chk(rd_c == ns && wr_c == 0, "R6 read strobe cycles", rd_c, ns);
      chk(rd_oe == (wide ? 2'b00 : 2'b10), "R6 read lane enables", rd_oe, wide ? 2'b00 : 2'b10);
      if (!wide) chk(rd_bus[15:8] == addr[7:0], "R6 low address byte on upper lane", rd_bus[15:8], addr[7:0]);
      expd = addr[15:0] ^ 16'h5A5A;
      if (!wide) expd = {8'h00, expd[7:0]};
      chk(got == expd, "R6 read data", got, expd);
    end
    chk(done_c == 1, "R7 single done pulse", done_c, 1);
    chk(hold_c == nh, "R8 hold phase length", hold_c, nh);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bus_oe == 2'b00 && rd_n && wr_n && !ale && !done && req_ready, "R1 reset state",
        {bus_oe, rd_n, wr_n, ale, done, req_ready}, {2'b00, 5'b11001});

    // R11: no valid, no access
    seen = 0;
    repeat (5) begin @(negedge clk); if (!rd_n || !wr_n || ale) seen++; end
    chk(seen == 0, "R11 idle without valid", seen, 0);

    // table walk
    for (int v = 0; v < NV; v++)
      run_access(VECS[v][42], VECS[v][41], VECS[v][40:17], VECS[v][16:1], VECS[v][0]);

    // R11: ready low while busy
    @(negedge clk);
    req_wide = 1; req_write = 1; req_addr = 24'h000200; req_valid = 1;
    @(posedge clk); @(negedge clk);
    chk(!req_ready, "R11 ready low during access", req_ready, 0);
    req_valid = 0;
    while (!req_ready) @(negedge clk);

    // R10: zero-length fields behave as one cycle
    cfg_addr_cycles = 0; cfg_strobe_cycles = 0; cfg_hold_cycles = 0;
    run_access(1'b1, 1'b0, 24'h00F00F, 16'h0000, 1'b1);
    // R10 longer phases too
    cfg_addr_cycles = 4'd4; cfg_strobe_cycles = 4'd5; cfg_hold_cycles = 4'd3;
    run_access(1'b0, 1'b1, 24'h777701, 16'h0099, 1'b1);

    // R4: active-low ALE
    cfg_ale_low = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(ale == 1'b1, "R4 idle level active-low", ale, 1);
    run_access(1'b0, 1'b1, 24'h888802, 16'h0042, 1'b1);
    run_access(1'b0, 1'b0, 24'h888803, 16'h0000, 1'b0);
    cfg_ale_low = 1'b0;
    @(negedge clk);

    // R9: flag mode together with a pending request
    cfg_flag_mode = 1'b1; req_valid = 1'b1; req_wide = 1; req_write = 1;
    @(negedge clk);
    chk(!req_ready, "R9 ready low in flag mode", req_ready, 0);
    seen = 0;
    repeat (6) begin @(negedge clk); if (!rd_n || !wr_n || ale || bus_oe != 0) seen++; end
    chk(seen == 0, "R9 pins quiet in flag mode", seen, 0);
    req_valid = 1'b0; cfg_flag_mode = 1'b0;
    @(negedge clk);

    // R9: abort during a long read strobe, no done, tracker invalidated
    cfg_strobe_cycles = 4'd15;
    run_access(1'b0, 1'b1, 24'h999900, 16'h0001, 1'b1);
    @(negedge clk);
    req_wide = 0; req_write = 0; req_addr = 24'h999901; req_valid = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    while (rd_n) @(negedge clk);
    repeat (2) @(negedge clk);
    cfg_flag_mode = 1'b1;
    seen = 0;
    @(negedge clk);
    chk(rd_n && bus_oe == 0, "R9 abort releases strobe", {rd_n, bus_oe}, 3'b100);
    repeat (20) begin @(negedge clk); if (done) seen++; end
    chk(seen == 0, "R9 no done after abort", seen, 0);
    cfg_flag_mode = 1'b0;
    cfg_strobe_cycles = 4'd2;
    run_access(1'b0, 1'b1, 24'h999902, 16'h0005, 1'b1);  // R3 fresh latch after abort

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule